// File: doc/BRIEF.md
# USB 2.0 Host Controller Interrupt and Error Status

This block holds the interrupt status of a USB 2.0 host controller and decides when each status bit is raised. It counts microframes into a frame index and flags each wrap of the 1024-entry frame list. It collects completion events and holds them until the programmed interrupt threshold interval ends. It reports a read abort from the system bus as a fatal host error and stops the controller. The status bits are sticky and are cleared by writing a one. A single level-sensitive interrupt line is driven from the status bits that the enable mask lets through.

A completion interrupt is released at the threshold boundary only after the internal write buffer has accepted the status of the last completed transaction. The block does not wait for the memory write to be seen outside the controller. Two small write-back helpers sit beside the status logic. One decides whether the error counter of a split transaction may change. The other decides whether a periodic structure fetch may mark a missed microframe. A fetch that fails the late-start test leaves the mark to a later access that passes it.

Top module: `usb_hc_irq_status`

## Requirements
- R1: After reset `halted` is 1, `sts[4:0]` is 0, `frindex` is 0 and `irq` is 0.
- R2: `run_cmd` clears `halted` at the next edge. `rd_abort` sets `sts[3]` (fatal host error) and `halted` at the next edge, and wins over a `run_cmd` in the same cycle. While `halted` is 1, `frindex` does not advance, and only `run_cmd` or reset leaves the halt.
- R3: `frindex` counts `uframe_tick` pulses and wraps from 8191 to 0 (1024 frames of 8 microframes). `sts[2]` (frame list rollover) is set at the edge where it wraps and not before.
- R4: A `xfer_done` with `xfer_ioc` is held until the threshold boundary. The interval is 2^`thresh_sel` microframes, with code 7 meaning 64, counted from the last `run_cmd`. `sts[0]` is set at the boundary tick when the write buffer has accepted all status.
- R5: Any `xfer_done` marks status as unposted until a later `wbuf_ack`. If a boundary finds status unposted, `sts[0]`/`sts[1]` is set at the second edge after the `wbuf_ack`, not at the boundary.
- R6: A `xfer_done` with `xfer_err` raises `sts[1]` (error interrupt) under the same threshold and posting rules, without touching `sts[0]`.
- R7: A one in `sts_clr[i]` clears `sts[i]` for i = 0..3. A new set in the same cycle wins over the clear. `sts[5]` mirrors `halted` and cannot be cleared this way.
- R8: `irq` is 1 exactly when some bit of `sts[3:0] & ien` is 1.
- R9: `sts[4]` (data buffer error) is always 0.
- R10: One cycle after `cs_valid`, `cerr_wb_vld` is 1 and `cerr_wb` holds the new error count. The count is unchanged for an interrupt IN split (`cs_int_in`) whose complete-split criteria are not met (`cs_crit_ok`=0). Otherwise, when `cs_err` is 1, it drops by one and saturates at 0. Without an error it is unchanged.
- R11: One cycle after `pf_fetch`, `mmf_wb` is 1 only if `pf_missed` was 1 and `pf_late_fail` was 0. A failed late-start test never marks a missed microframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run_cmd | input | 1 | Start command; leaves halt, restarts threshold count |
| uframe_tick | input | 1 | One pulse per microframe |
| thresh_sel | input | 3 | Threshold interval code, 2^code microframes, 7 = 64 |
| xfer_done | input | 1 | Transaction completed |
| xfer_ioc | input | 1 | Completion requests interrupt on complete |
| xfer_err | input | 1 | Completion ended in error |
| wbuf_ack | input | 1 | Write buffer accepted all outstanding status |
| rd_abort | input | 1 | Master or target abort on a controller read |
| sts_clr | input | 4 | Write-one-to-clear strobes for sts[3:0] |
| ien | input | 4 | Interrupt enables for sts[3:0] |
| pf_fetch | input | 1 | Periodic structure fetched |
| pf_missed | input | 1 | Fetched structure's microframe has passed |
| pf_late_fail | input | 1 | Fetch failed the late-start test |
| cs_valid | input | 1 | Split transaction result valid |
| cs_int_in | input | 1 | Result is an interrupt IN split |
| cs_crit_ok | input | 1 | Complete-split execution criteria met |
| cs_err | input | 1 | Transaction error seen |
| cs_cerr_in | input | 2 | Current error count |
| sts | output | 6 | {halted, 0, fatal, rollover, error int, completion int} |
| halted | output | 1 | Controller halted |
| frindex | output | 13 | Microframe index |
| irq | output | 1 | Level interrupt |
| mmf_wb | output | 1 | Write back missed-microframe mark |
| cerr_wb_vld | output | 1 | Error count write-back valid |
| cerr_wb | output | 2 | Error count to write back |

## Verification
The bench steps the index across the wrap and checks the rollover bit both one tick before and at the wrap. An off-by-one counter would raise it a tick early or late. It programs intervals of 1, 4 and 64 microframes and checks that the completion bit stays low up to the last tick. It also withholds the buffer acknowledge across a boundary, which catches a design that fires on the boundary alone. It drives abort, run and clear strobes in the same cycle, so a wrong priority shows as a lost halt or a lost status bit. Split error counts are checked at zero and with unmet criteria, and fetches are checked with a failed late-start test.

// File: rtl/usb_hc_irq_status.sv
module usb_hc_irq_status #(
  parameter int FRAME_ENTRIES = 1024,
  parameter int UF_PER_FRAME  = 8,
  parameter int MAX_THR_LOG   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_cmd,
  input  logic                 uframe_tick,
  input  logic [2:0]           thresh_sel,
  input  logic                 xfer_done,
  input  logic                 xfer_ioc,
  input  logic                 xfer_err,
  input  logic                 wbuf_ack,
  input  logic                 rd_abort,
  input  logic [3:0]           sts_clr,
  input  logic [3:0]           ien,
  input  logic                 pf_fetch,
  input  logic                 pf_missed,
  input  logic                 pf_late_fail,
  input  logic                 cs_valid,
  input  logic                 cs_int_in,
  input  logic                 cs_crit_ok,
  input  logic                 cs_err,
  input  logic [1:0]           cs_cerr_in,
  output logic [5:0]           sts,
  output logic                 halted,
  output logic [$clog2(FRAME_ENTRIES*UF_PER_FRAME)-1:0] frindex,
  output logic                 irq,
  output logic                 mmf_wb,
  output logic                 cerr_wb_vld,
  output logic [1:0]           cerr_wb
);
  localparam int IDX_W  = $clog2(FRAME_ENTRIES*UF_PER_FRAME);
  localparam int IDX_MAX = FRAME_ENTRIES*UF_PER_FRAME - 1;
  localparam int TC_W   = MAX_THR_LOG + 1;

  logic [TC_W-1:0] tcnt;
  logic pend_c, pend_e, due_c, due_e, posted;
  logic st_c, st_e, st_r, st_f;

  wire       tick    = uframe_tick & ~halted;
  wire [2:0] sel_eff = (thresh_sel > 3'(MAX_THR_LOG)) ? 3'(MAX_THR_LOG) : thresh_sel;
  wire [TC_W-1:0] ivl = TC_W'(1) << sel_eff;
  wire       bnd     = tick && (tcnt == ivl - TC_W'(1));
  wire       wrap    = tick && (frindex == IDX_W'(IDX_MAX));
  wire       fire_c  = (due_c | (bnd & pend_c)) & posted;
  wire       fire_e  = (due_e | (bnd & pend_e)) & posted;
  wire [1:0] cerr_dec = (cs_cerr_in == 2'd0) ? 2'd0 : cs_cerr_in - 2'd1;
  wire       cerr_keep = (cs_int_in & ~cs_crit_ok) | ~cs_err;

  assign sts = {halted, 1'b0, st_f, st_r, st_e, st_c};
  assign irq = |(sts[3:0] & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted <= 1'b1;
      tcnt <= '0;
      frindex <= '0;
      posted <= 1'b1;
      {pend_c, pend_e, due_c, due_e} <= '0;
      {st_c, st_e, st_r, st_f} <= '0;
      mmf_wb <= 1'b0;
      cerr_wb_vld <= 1'b0;
      cerr_wb <= '0;
    end else begin
      if (rd_abort) halted <= 1'b1;
      else if (run_cmd) halted <= 1'b0;

      if (run_cmd && !rd_abort) tcnt <= '0;
      else if (tick) tcnt <= bnd ? '0 : tcnt + TC_W'(1);

      if (tick) frindex <= wrap ? '0 : frindex + IDX_W'(1);

      if (xfer_done) posted <= 1'b0;
      else if (wbuf_ack) posted <= 1'b1;

      pend_c <= (pend_c & ~bnd) | (xfer_done & xfer_ioc);
      pend_e <= (pend_e & ~bnd) | (xfer_done & xfer_err);
      due_c  <= ~fire_c & (due_c | (bnd & pend_c));
      due_e  <= ~fire_e & (due_e | (bnd & pend_e));

      st_c <= fire_c   | (st_c & ~sts_clr[0]);
      st_e <= fire_e   | (st_e & ~sts_clr[1]);
      st_r <= wrap     | (st_r & ~sts_clr[2]);
      st_f <= rd_abort | (st_f & ~sts_clr[3]);

      mmf_wb <= pf_fetch & pf_missed & ~pf_late_fail;
      cerr_wb_vld <= cs_valid;
      if (cs_valid) cerr_wb <= cerr_keep ? cs_cerr_in : cerr_dec;
    end
  end

  p_fatal_halts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_abort |=> (halted && sts[3]));

  p_halt_freezes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(frindex));

  p_roll_at_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[2]) |-> (frindex == '0));

  p_cmpl_posted_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[0]) |-> $past(posted));

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 4'd0) |-> !irq);

  p_cerr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_valid && cs_int_in && !cs_crit_ok) |=> (cerr_wb == $past(cs_cerr_in)));

  p_mmf_late_fail_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_fetch && pf_late_fail) |=> !mmf_wb);
endmodule

// File: tb/usb_hc_irq_status_tb_top.sv
`timescale 1ns/1ps
module usb_hc_irq_status_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_cmd = 0, uframe_tick = 0, xfer_done = 0, xfer_ioc = 0, xfer_err = 0;
  logic wbuf_ack = 0, rd_abort = 0, pf_fetch = 0, pf_missed = 0, pf_late_fail = 0;
  logic cs_valid = 0, cs_int_in = 0, cs_crit_ok = 0, cs_err = 0;
  logic [1:0] cs_cerr_in = 0;
  logic [2:0] thresh_sel = 0;
  logic [3:0] sts_clr = 0, ien = 0;
  logic [5:0] sts;
  logic halted, irq, mmf_wb, cerr_wb_vld;
  logic [12:0] frindex;
  logic [1:0] cerr_wb;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  usb_hc_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .run_cmd(run_cmd), .uframe_tick(uframe_tick),
    .thresh_sel(thresh_sel), .xfer_done(xfer_done), .xfer_ioc(xfer_ioc),
    .xfer_err(xfer_err), .wbuf_ack(wbuf_ack), .rd_abort(rd_abort),
    .sts_clr(sts_clr), .ien(ien), .pf_fetch(pf_fetch), .pf_missed(pf_missed),
    .pf_late_fail(pf_late_fail), .cs_valid(cs_valid), .cs_int_in(cs_int_in),
    .cs_crit_ok(cs_crit_ok), .cs_err(cs_err), .cs_cerr_in(cs_cerr_in),
    .sts(sts), .halted(halted), .frindex(frindex), .irq(irq), .mmf_wb(mmf_wb),
    .cerr_wb_vld(cerr_wb_vld), .cerr_wb(cerr_wb));

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; cyc(2); rst_n = 1; cyc(1);
  endtask

  task automatic start();
    run_cmd = 1; cyc(); run_cmd = 0;
  endtask

  task automatic ticks(int n);
    uframe_tick = 1; cyc(n); uframe_tick = 0;
  endtask

  task automatic done_posted(bit ioc, bit err);
    xfer_done = 1; xfer_ioc = ioc; xfer_err = err; cyc();
    xfer_done = 0; xfer_ioc = 0; xfer_err = 0;
    wbuf_ack = 1; cyc(); wbuf_ack = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 halted", halted, 1);
    chk("R1 sts", sts[4:0], 0);
    chk("R1 frindex", frindex, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_run_halt();
    do_reset();
    ticks(3);
    chk("R2 index frozen while halted", frindex, 0);
    start();
    chk("R2 run clears halt", halted, 0);
    ticks(5);
    chk("R2 index advances", frindex, 5);
    run_cmd = 1; rd_abort = 1; cyc(); run_cmd = 0; rd_abort = 0;
    chk("R2 abort beats run", halted, 1);
    chk("R2 fatal status", sts[3], 1);
    ticks(4);
    chk("R2 index held after halt", frindex, 5);
    start();
    chk("R2 run leaves halt", halted, 0);
  endtask

  task automatic t_rollover();
    do_reset(); start();
    ticks(8191);
    chk("R3 no rollover before wrap", sts[2], 0);
    chk("R3 index at max", frindex, 8191);
    ticks(1);
    chk("R3 rollover at wrap", sts[2], 1);
    chk("R3 index wrapped", frindex, 0);
  endtask

  task automatic t_thresh(int sel, int len);
    do_reset(); thresh_sel = 3'(sel); start();
    done_posted(1, 0);
    ticks(len - 1);
    chk($sformatf("R4 no completion before %0d", len), sts[0], 0);
    ticks(1);
    chk($sformatf("R4 completion at %0d", len), sts[0], 1);
    chk("R6 error bit untouched by ioc", sts[1], 0);
  endtask

  task automatic t_defer();
    do_reset(); thresh_sel = 3'd1; start();
    xfer_done = 1; xfer_ioc = 1; cyc(); xfer_done = 0; xfer_ioc = 0;
    ticks(2);
    chk("R5 held while unposted", sts[0], 0);
    wbuf_ack = 1; cyc(); wbuf_ack = 0;
    chk("R5 not yet one edge after ack", sts[0], 0);
    cyc();
    chk("R5 set two edges after ack", sts[0], 1);
  endtask

  task automatic t_err();
    do_reset(); thresh_sel = 3'd0; start();
    done_posted(0, 1);
    chk("R6 error held before boundary", sts[1], 0);
    ticks(1);
    chk("R6 error interrupt", sts[1], 1);
    chk("R6 completion bit clear", sts[0], 0);
  endtask

  task automatic t_w1c_irq();
    do_reset(); start();
    rd_abort = 1; cyc(); rd_abort = 0;
    ien = 4'b0000; cyc();
    chk("R8 masked irq", irq, 0);
    ien = 4'b0100; cyc();
    chk("R8 other enable irq", irq, 0);
    ien = 4'b1000; cyc();
    chk("R8 enabled irq", irq, 1);
    sts_clr = 4'b0111; cyc(); sts_clr = 0;
    chk("R7 other clears leave fatal", sts[3], 1);
    sts_clr = 4'b1000; cyc(); sts_clr = 0;
    chk("R7 fatal cleared", sts[3], 0);
    chk("R7 halted not cleared", sts[5], 1);
    chk("R8 irq drops", irq, 0);
    sts_clr = 4'b1000; rd_abort = 1; cyc(); sts_clr = 0; rd_abort = 0;
    chk("R7 set wins over clear", sts[3], 1);
    chk("R9 data buffer error never set", sts[4], 0);
    ien = 0;
  endtask

  task automatic cs(bit intin, bit ok, bit err, int cin, int exp, string tag);
    cs_valid = 1; cs_int_in = intin; cs_crit_ok = ok; cs_err = err; cs_cerr_in = 2'(cin);
    cyc(); cs_valid = 0;
    chk({tag, " vld"}, cerr_wb_vld, 1);
    chk(tag, cerr_wb, exp);
  endtask

  task automatic t_cerr();
    cs(1, 0, 1, 3, 3, "R10 criteria unmet keeps count");
    cs(1, 1, 1, 3, 2, "R10 criteria met decrements");
    cs(0, 0, 1, 0, 0, "R10 saturates at zero");
    cs(0, 0, 0, 2, 2, "R10 no error keeps count");
  endtask

  task automatic pf(bit m, bit f, int exp, string tag);
    pf_fetch = 1; pf_missed = m; pf_late_fail = f; cyc(); pf_fetch = 0;
    chk(tag, mmf_wb, exp);
  endtask

  task automatic t_mmf();
    pf(1, 1, 0, "R11 late-start fail no mark");
    pf(1, 0, 1, "R11 later pass marks");
    pf(0, 0, 0, "R11 not missed no mark");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_run_halt();
    t_rollover();
    t_thresh(0, 1);
    t_thresh(2, 4);
    t_thresh(7, 64);
    t_defer();
    t_err();
    t_w1c_irq();
    t_cerr();
    t_mmf();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule